// File: doc/BRIEF.md
# NAND Flash Access Phase Sequencer

This block sits between a host request port and an asynchronous NAND flash or PC Card style memory. It takes one host read or write at a time and turns it into one or more strobe cycles on the memory pins. Each memory access runs through three counted phases. A setup phase asserts chip select alone. A wait phase pulses the read or write strobe low. A hold phase keeps chip select asserted after the strobe has returned high. On writes, a fourth programmable delay, counted from the start of each access, decides when the data bus starts to be driven.

Three independent timing sets are provided: one for the common memory space, one for the attribute space and one for the I/O space. The host picks the space with each request. A host transfer that is wider than the memory is split into consecutive memory accesses at consecutive memory word addresses. A size combination the memory cannot take is answered with an error and no bus activity. The timing inputs are read live, so software must hold them stable while an access is in flight.

Top module: `nand_phase_seq`

## Requirements
- R1: After reset, and at once while reset is asserted in the middle of an access, mem_cs_n, mem_oe_n and mem_we_n are high, and mem_doe and rsp_done are low.
- R2: A request is accepted on a rising edge where req_valid is high and the block is idle. Each memory access then holds mem_cs_n low for S setup cycles with both strobes high, then W cycles with the strobe low, then H hold cycles with both strobes high. S, W and H come from the selected timing set.
- R3: Reads pulse only mem_oe_n and writes pulse only mem_we_n. The two strobes are never low together, and neither is low while mem_cs_n is high.
- R4: On a write, mem_doe rises D cycles after the first setup cycle of each access (that cycle counting as cycle 0) and stays high to the end of the hold phase. mem_doe never rises on a read.
- R5: A timing field value of zero acts as one cycle, so every phase, and the drive delay, lasts at least one cycle.
- R6: req_space 0 selects the common timing set, 1 the attribute set and 2 the I/O set. Set k is taken from bits [k*TW +: TW] of cfg_setup, cfg_wait, cfg_hold and cfg_drive.
- R7: req_size 0, 1 and 2 mean 8, 16 and 32 bits. With mem_wide=0 (8-bit memory) these give 1, 2 and 4 accesses. With mem_wide=1 (16-bit memory), sizes 0 and 1 give one access and size 2 gives two. This holds for reads and writes alike.
- R8: An 8-bit write to a 16-bit memory, req_size 3 and req_space 3 are rejected. rsp_done and rsp_err rise in the cycle after acceptance, mem_cs_n never falls, and rsp_rdata reads zero.
- R9: Sub-access k uses mem_addr = req_addr + k. During a write strobe, mem_dout carries req_wdata[8k +: 8] zero-extended on an 8-bit memory, or req_wdata[16k +: 16] on a 16-bit memory. mem_addr does not change during the wait and hold phases.
- R10: Read data is sampled on the last wait cycle of each access and placed in byte lane k (8-bit memory) or halfword lane k (16-bit memory), least significant first. rsp_rdata is masked to the host size, so an 8-bit read of a 16-bit memory returns only mem_din[7:0].
- R11: After the last hold cycle, rsp_done is high for exactly one cycle. rsp_err is low on success, and rsp_rdata is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present; held until rsp_done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Host size: 0 = 8, 1 = 16, 2 = 32 bits |
| req_space | input | 2 | 0 common, 1 attribute, 2 I/O |
| req_addr | input | ADDR_W | Memory word address of the first sub-access |
| req_wdata | input | 32 | Host write data |
| mem_wide | input | 1 | Memory width: 0 = 8 bits, 1 = 16 bits |
| cfg_setup | input | NSP*TW | Setup cycles per space |
| cfg_wait | input | NSP*TW | Strobe cycles per space |
| cfg_hold | input | NSP*TW | Hold cycles per space |
| cfg_drive | input | NSP*TW | Write data drive delay per space |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Rejected request, valid with rsp_done |
| rsp_rdata | output | 32 | Assembled read data, valid with rsp_done |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | ADDR_W | Memory word address |
| mem_dout | output | 16 | Write data to memory |
| mem_doe | output | 1 | Write data bus enable |
| mem_din | input | 16 | Read data from memory |

## Verification
The hardest case to reach is a multi-access split where the lane index, the address increment, the per-access drive delay and the final masking all have to agree. The worst of these is a four-access word write to an 8-bit memory, where chip select stays low from one access into the next. The stimulus table sweeps every size against both memory widths and all three spaces, each space with its own distinct timing, so a wrong lane or a wrong set shows up as a cycle-count or data mismatch. A memory model that returns data derived from the address makes every sub-access tell apart on reads. A directed test programs all-zero timing to reach the minimum one-cycle phases, and another pulls reset during a split write.

// File: rtl/nps_pkg.sv
package nps_pkg;
    localparam int HOST_W     = 32;
    localparam int MEM_W      = 16;
    localparam int NUM_SPACES = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT,
        ST_HOLD,
        ST_DONE
    } phase_e;
endpackage

// File: rtl/nps_size_plan.sv
module nps_size_plan #(
    parameter int NSP = 3
) (
    input  logic       wr,
    input  logic [1:0] size,
    input  logic       wide,
    input  logic [1:0] space,
    output logic       reject,
    output logic [2:0] last_beat
);
    always_comb begin
        reject    = 1'b0;
        last_beat = 3'd0;
        if (int'(space) >= NSP || size == 2'd3) begin
            reject = 1'b1;
        end else if (wide) begin
            case (size)
                2'd0:    reject    = wr;
                2'd2:    last_beat = 3'd1;
                default: last_beat = 3'd0;
            endcase
        end else begin
            case (size)
                2'd1:    last_beat = 3'd1;
                2'd2:    last_beat = 3'd3;
                default: last_beat = 3'd0;
            endcase
        end
    end
endmodule

// File: rtl/nps_timing_sel.sv
module nps_timing_sel #(
    parameter int NSP = 3,
    parameter int TW  = 4
) (
    input  logic [1:0]        space,
    input  logic [NSP*TW-1:0] cfg_setup,
    input  logic [NSP*TW-1:0] cfg_wait,
    input  logic [NSP*TW-1:0] cfg_hold,
    input  logic [NSP*TW-1:0] cfg_drive,
    output logic [TW-1:0]     t_setup,
    output logic [TW-1:0]     t_wait,
    output logic [TW-1:0]     t_hold,
    output logic [TW-1:0]     t_drive
);
    function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
        return (v == '0) ? TW'(1) : v;
    endfunction

    logic [TW-1:0] set_s [NSP];
    logic [TW-1:0] set_w [NSP];
    logic [TW-1:0] set_h [NSP];
    logic [TW-1:0] set_d [NSP];

    for (genvar g = 0; g < NSP; g++) begin : g_set
        assign set_s[g] = at_least_one(cfg_setup[g*TW +: TW]);
        assign set_w[g] = at_least_one(cfg_wait[g*TW +: TW]);
        assign set_h[g] = at_least_one(cfg_hold[g*TW +: TW]);
        assign set_d[g] = at_least_one(cfg_drive[g*TW +: TW]);
    end

    always_comb begin
        t_setup = set_s[0];
        t_wait  = set_w[0];
        t_hold  = set_h[0];
        t_drive = set_d[0];
        for (int i = 1; i < NSP; i++) begin
            if (int'(space) == i) begin
                t_setup = set_s[i];
                t_wait  = set_w[i];
                t_hold  = set_h[i];
                t_drive = set_d[i];
            end
        end
    end
endmodule

// File: rtl/nps_lane_mux.sv
module nps_lane_mux #(
    parameter int HOST_W = 32,
    parameter int MEM_W  = 16
) (
    input  logic [1:0]        beat,
    input  logic              wide,
    input  logic [HOST_W-1:0] wdata,
    input  logic [MEM_W-1:0]  din,
    input  logic [HOST_W-1:0] rdata_in,
    output logic [MEM_W-1:0]  dout,
    output logic [HOST_W-1:0] rdata_out
);
    localparam int BW = 8;

    always_comb begin
        dout      = '0;
        rdata_out = rdata_in;
        if (wide) begin
            dout = wdata[int'(beat[0])*MEM_W +: MEM_W];
            rdata_out[int'(beat[0])*MEM_W +: MEM_W] = din;
        end else begin
            dout[BW-1:0] = wdata[int'(beat)*BW +: BW];
            rdata_out[int'(beat)*BW +: BW] = din[BW-1:0];
        end
    end
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
    import nps_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int TW     = 4,
    parameter int NSP    = NUM_SPACES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [1:0]           req_space,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [HOST_W-1:0]    req_wdata,
    input  logic                 mem_wide,
    input  logic [NSP*TW-1:0]    cfg_setup,
    input  logic [NSP*TW-1:0]    cfg_wait,
    input  logic [NSP*TW-1:0]    cfg_hold,
    input  logic [NSP*TW-1:0]    cfg_drive,
    output logic                 rsp_done,
    output logic                 rsp_err,
    output logic [HOST_W-1:0]    rsp_rdata,
    output logic                 mem_cs_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [MEM_W-1:0]     mem_dout,
    output logic                 mem_doe,
    input  logic [MEM_W-1:0]     mem_din
);
    localparam int EW = TW + 2;

    typedef struct packed {
        phase_e              phase;
        logic                wr;
        logic [1:0]          size;
        logic                wide;
        logic [1:0]          space;
        logic [ADDR_W-1:0]   base;
        logic [HOST_W-1:0]   wdata;
        logic [2:0]          beat;
        logic [2:0]          last;
        logic [TW-1:0]       cnt;
        logic [EW-1:0]       elapsed;
        logic [HOST_W-1:0]   rdata;
        logic                err;
    } seq_t;

    seq_t q, d;

    function automatic logic [EW-1:0] inc_sat(input logic [EW-1:0] v);
        return (v == '1) ? v : v + EW'(1);
    endfunction

    logic              plan_reject;
    logic [2:0]        plan_last;
    logic [1:0]        sel_space;
    logic [TW-1:0]     t_setup, t_wait, t_hold, t_drive;
    logic [MEM_W-1:0]  lane_dout;
    logic [HOST_W-1:0] lane_rdata;
    logic              in_access;
    logic [HOST_W-1:0] size_mask;

    assign sel_space = (q.phase == ST_IDLE) ? req_space : q.space;

    nps_size_plan #(.NSP(NSP)) i_plan (
        .wr        (req_write),
        .size      (req_size),
        .wide      (mem_wide),
        .space     (req_space),
        .reject    (plan_reject),
        .last_beat (plan_last)
    );

    nps_timing_sel #(.NSP(NSP), .TW(TW)) i_tsel (
        .space     (sel_space),
        .cfg_setup (cfg_setup),
        .cfg_wait  (cfg_wait),
        .cfg_hold  (cfg_hold),
        .cfg_drive (cfg_drive),
        .t_setup   (t_setup),
        .t_wait    (t_wait),
        .t_hold    (t_hold),
        .t_drive   (t_drive)
    );

    nps_lane_mux #(.HOST_W(HOST_W), .MEM_W(MEM_W)) i_lane (
        .beat      (q.beat[1:0]),
        .wide      (q.wide),
        .wdata     (q.wdata),
        .din       (mem_din),
        .rdata_in  (q.rdata),
        .dout      (lane_dout),
        .rdata_out (lane_rdata)
    );

    always_comb begin
        d = q;
        case (q.phase)
            ST_IDLE: begin
                if (req_valid) begin
                    d.wr      = req_write;
                    d.size    = req_size;
                    d.wide    = mem_wide;
                    d.space   = req_space;
                    d.base    = req_addr;
                    d.wdata   = req_wdata;
                    d.beat    = 3'd0;
                    d.last    = plan_last;
                    d.elapsed = '0;
                    d.rdata   = '0;
                    d.cnt     = t_setup - TW'(1);
                    d.err     = plan_reject;
                    d.phase   = plan_reject ? ST_DONE : ST_SETUP;
                end
            end
            ST_SETUP: begin
                d.elapsed = inc_sat(q.elapsed);
                if (q.cnt == '0) begin
                    d.phase = ST_WAIT;
                    d.cnt   = t_wait - TW'(1);
                end else begin
                    d.cnt = q.cnt - TW'(1);
                end
            end
            ST_WAIT: begin
                d.elapsed = inc_sat(q.elapsed);
                if (q.cnt == '0) begin
                    if (!q.wr) begin
                        d.rdata = lane_rdata;
                    end
                    d.phase = ST_HOLD;
                    d.cnt   = t_hold - TW'(1);
                end else begin
                    d.cnt = q.cnt - TW'(1);
                end
            end
            ST_HOLD: begin
                if (q.cnt == '0) begin
                    if (q.beat == q.last) begin
                        d.phase = ST_DONE;
                    end else begin
                        d.beat    = q.beat + 3'd1;
                        d.phase   = ST_SETUP;
                        d.cnt     = t_setup - TW'(1);
                        d.elapsed = '0;
                    end
                end else begin
                    d.cnt     = q.cnt - TW'(1);
                    d.elapsed = inc_sat(q.elapsed);
                end
            end
            ST_DONE: begin
                d.phase = ST_IDLE;
            end
            default: begin
                d.phase = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.size)
            2'd0:    size_mask = HOST_W'(32'h0000_00FF);
            2'd1:    size_mask = HOST_W'(32'h0000_FFFF);
            default: size_mask = '1;
        endcase
    end

    assign in_access = (q.phase == ST_SETUP) || (q.phase == ST_WAIT) || (q.phase == ST_HOLD);
    assign mem_cs_n  = !in_access;
    assign mem_oe_n  = !((q.phase == ST_WAIT) && !q.wr);
    assign mem_we_n  = !((q.phase == ST_WAIT) && q.wr);
    assign mem_doe   = in_access && q.wr && (q.elapsed >= EW'(t_drive));
    assign mem_addr  = q.base + ADDR_W'(q.beat);
    assign mem_dout  = lane_dout;
    assign rsp_done  = (q.phase == ST_DONE);
    assign rsp_err   = rsp_done && q.err;
    assign rsp_rdata = rsp_done ? (q.rdata & size_mask) : '0;

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

    p_drive_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_doe |-> (!mem_cs_n && mem_oe_n));

    p_reject_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_err) |-> (mem_cs_n && $past(mem_cs_n)));

    p_addr_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && q.phase != ST_SETUP) |-> $stable(mem_addr));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

// File: tb/test_nand_phase_seq.sv
module test_nand_phase_seq;
    localparam int ADDR_W = 16;
    localparam int TW     = 4;
    localparam int NSP    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = '0;
    logic [1:0]        req_space = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              mem_wide = 1'b0;
    logic [NSP*TW-1:0] cfg_setup, cfg_wait, cfg_hold, cfg_drive;
    logic              rsp_done, rsp_err;
    logic [31:0]       rsp_rdata;
    logic              mem_cs_n, mem_oe_n, mem_we_n, mem_doe;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_dout, mem_din;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    function automatic logic [15:0] din_f(input logic [ADDR_W-1:0] a);
        return {~a[7:0], a[7:0] ^ 8'hC3};
    endfunction

    assign mem_din = din_f(mem_addr);

    nand_phase_seq #(.ADDR_W(ADDR_W), .TW(TW), .NSP(NSP)) i_nand_phase_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_space(req_space), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_wide(mem_wide), .cfg_setup(cfg_setup),
        .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .cfg_drive(cfg_drive),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int eff(input logic [NSP*TW-1:0] f, input logic [1:0] sp);
        int v;
        v = int'(f[int'(sp)*TW +: TW]);
        return (v == 0) ? 1 : v;
    endfunction

    typedef struct packed {
        logic        wide;
        logic        wr;
        logic [1:0]  size;
        logic [1:0]  space;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [2:0]  beats;
        logic        err;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 2'd0, 2'd0, 16'h0010, 32'h0,          3'd1, 1'b0},
        '{1'b0, 1'b1, 2'd1, 2'd1, 16'h0020, 32'h0000_BEEF,  3'd2, 1'b0},
        '{1'b0, 1'b0, 2'd2, 2'd2, 16'h00F0, 32'h0,          3'd4, 1'b0},
        '{1'b0, 1'b1, 2'd2, 2'd0, 16'h1234, 32'hCAFE_F00D,  3'd4, 1'b0},
        '{1'b1, 1'b0, 2'd0, 2'd1, 16'h0040, 32'h0,          3'd1, 1'b0},
        '{1'b1, 1'b1, 2'd0, 2'd0, 16'h0044, 32'h0000_0055,  3'd0, 1'b1},
        '{1'b1, 1'b0, 2'd1, 2'd2, 16'h0050, 32'h0,          3'd1, 1'b0},
        '{1'b1, 1'b1, 2'd1, 2'd1, 16'h0060, 32'h0000_1357,  3'd1, 1'b0},
        '{1'b1, 1'b0, 2'd2, 2'd0, 16'h0070, 32'h0,          3'd2, 1'b0},
        '{1'b1, 1'b1, 2'd2, 2'd2, 16'h0080, 32'h89AB_CDEF,  3'd2, 1'b0},
        '{1'b0, 1'b0, 2'd3, 2'd0, 16'h0090, 32'h0,          3'd0, 1'b1},
        '{1'b1, 1'b1, 2'd1, 2'd3, 16'h00A0, 32'h0000_2468,  3'd0, 1'b1}
    };

    task automatic run_vec(input vec_t v);
        int s, w, h, dr, t, nb;
        int cs_cnt = 0, stb_cnt = 0, pulses = 0, first_stb = -1, first_doe = -1;
        int doe_cnt = 0, done_idx = -1, addr_bad = 0, data_bad = 0, wrong_stb = 0;
        logic prev_stb = 1'b0;
        logic got_err = 1'b0;
        logic [31:0] got_rd = '0;
        logic [31:0] exp_rd = '0;
        logic [15:0] exp_lane;
        nb = int'(v.beats);
        s  = eff(cfg_setup, v.space);
        w  = eff(cfg_wait, v.space);
        h  = eff(cfg_hold, v.space);
        dr = eff(cfg_drive, v.space);
        t  = s + w + h;
        mem_wide  = v.wide;
        req_write = v.wr;
        req_size  = v.size;
        req_space = v.space;
        req_addr  = v.addr;
        req_wdata = v.wdata;
        req_valid = 1'b1;
        for (int idx = 0; idx < 300; idx++) begin
            logic stb;
            @(negedge clk);
            if (rsp_done) begin
                done_idx  = idx;
                got_err   = rsp_err;
                got_rd    = rsp_rdata;
                req_valid = 1'b0;
                break;
            end
            stb = !mem_oe_n || !mem_we_n;
            if (stb && !prev_stb) begin
                pulses++;
                if (pulses == 1) first_stb = idx;
                if (mem_addr !== v.addr + 16'(pulses - 1)) addr_bad++;
            end
            if (!mem_we_n) begin
                exp_lane = v.wide ? v.wdata[(pulses-1)*16 +: 16] : {8'h00, v.wdata[(pulses-1)*8 +: 8]};
                if (mem_dout !== exp_lane) data_bad++;
            end
            if ((v.wr && !mem_oe_n) || (!v.wr && !mem_we_n)) wrong_stb++;
            if (stb) stb_cnt++;
            if (!mem_cs_n) cs_cnt++;
            if (mem_doe) begin
                doe_cnt++;
                if (first_doe < 0) first_doe = idx;
            end
            prev_stb = stb;
        end
        req_valid = 1'b0;
        for (int k = 0; k < nb; k++) begin
            if (v.wide) exp_rd[k*16 +: 16] = din_f(v.addr + 16'(k));
            else        exp_rd[k*8 +: 8]   = din_f(v.addr + 16'(k))[7:0];
        end
        if (v.size == 2'd0) exp_rd = exp_rd & 32'h0000_00FF;
        if (v.size == 2'd1) exp_rd = exp_rd & 32'h0000_FFFF;
        if (v.err) begin
            chk("R8", "reject error flag", 32'(got_err), 32'd1);
            chk("R8", "reject done cycle", 32'(done_idx), 32'd0);
            chk("R8", "reject cs cycles", 32'(cs_cnt), 32'd0);
            chk("R8", "reject rdata", got_rd, 32'd0);
        end else begin
            chk("R11", "error flag on success", 32'(got_err), 32'd0);
            chk("R11", "done cycle", 32'(done_idx), 32'(nb * t));
            chk("R7", "access count", 32'(pulses), 32'(nb));
            chk("R2", "cs low cycles", 32'(cs_cnt), 32'(nb * t));
            chk("R2", "strobe low cycles", 32'(stb_cnt), 32'(nb * w));
            chk("R6", "first strobe cycle", 32'(first_stb), 32'(s));
            chk("R3", "strobe type", 32'(wrong_stb), 32'd0);
            chk("R9", "address mismatches", 32'(addr_bad), 32'd0);
            if (v.wr) begin
                chk("R9", "write lane mismatches", 32'(data_bad), 32'd0);
                chk("R4", "drive start", 32'(first_doe), 32'(dr));
                chk("R4", "drive cycles", 32'(doe_cnt), 32'(nb * (t - dr)));
            end else begin
                chk("R4", "no drive on read", 32'(doe_cnt), 32'd0);
                chk("R10", "read data", got_rd, exp_rd);
            end
        end
        @(negedge clk);
        chk("R11", "done single pulse", 32'(rsp_done), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cfg_setup = {4'd0, 4'd1, 4'd2};
        cfg_wait  = {4'd4, 4'd1, 4'd3};
        cfg_hold  = {4'd0, 4'd2, 4'd1};
        cfg_drive = {4'd3, 4'd0, 4'd1};
        repeat (3) @(negedge clk);
        chk("R1", "reset cs_n", 32'(mem_cs_n), 32'd1);
        chk("R1", "reset oe_n/we_n", 32'({mem_oe_n, mem_we_n}), 32'd3);
        chk("R1", "reset doe/done", 32'({mem_doe, rsp_done}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R5: all-zero common timing acts as one cycle per phase
        cfg_setup[3:0] = 4'd0;
        cfg_wait[3:0]  = 4'd0;
        cfg_hold[3:0]  = 4'd0;
        cfg_drive[3:0] = 4'd0;
        run_vec(VECS[0]);
        run_vec(VECS[3]);
        cfg_setup = {4'd0, 4'd1, 4'd2};
        cfg_wait  = {4'd4, 4'd1, 4'd3};
        cfg_hold  = {4'd0, 4'd2, 4'd1};
        cfg_drive = {4'd3, 4'd0, 4'd1};

        // R1: reset pulled in the middle of a split write
        mem_wide  = 1'b0;
        req_write = 1'b1;
        req_size  = 2'd2;
        req_space = 2'd0;
        req_addr  = 16'h0300;
        req_wdata = 32'h1122_3344;
        req_valid = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "write strobe before reset", 32'(mem_we_n), 32'd0);
        rst_n = 1'b0;
        req_valid = 1'b0;
        #1;
        chk("R1", "mid-access reset cs_n", 32'(mem_cs_n), 32'd1);
        chk("R1", "mid-access reset strobes", 32'({mem_oe_n, mem_we_n}), 32'd3);
        chk("R1", "mid-access reset doe", 32'(mem_doe), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", 32'({mem_cs_n, rsp_done}), 32'd2);
        run_vec(VECS[8]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule